// File: doc/BRIEF.md
# Programmable Interrupt Down-Timer

This block is a 16-bit periodic down-counter that raises a level interrupt each time it expires. Software programs it through three 16-bit registers: a control word, a modulus and a read-only view of the live count. A power-of-two prescaler, chosen by a 4-bit field, sets how often the counter steps. When the counter steps past zero it either restarts from the modulus (reload mode) or wraps to 0xFFFF (free-running mode), and a sticky flag is set. The interrupt output is the flag gated by an enable bit.

The flag is cleared by writing a one to it, and a modulus write clears it too. An overwrite bit decides whether a modulus write lands in the live counter at once or waits for the next reload. A control write that only touches the interrupt-enable and flag bits leaves the running count and the prescaler phase alone. Any other control write restarts the counter from the new limit and clears the prescaler. Two status bits for debug and low-power handling are stored and read back but have no effect.

Top module: `irq_down_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and the interrupt output is low.
- R2: Registers sit at byte offsets 0 (control), 2 (modulus) and 4 (count). The control word holds bit 0 enable, bit 1 reload mode, bit 2 flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 debug, bit 6 doze and bits 11:8 prescale select; bits 15:12 and 7 read as zero. Writes to offset 4 do not change the count.
- R3: While enabled, the count steps down once every 2^(P+1) clock cycles, P being the prescale select, the first step coming 2^(P+1) cycles after the restarting control write.
- R4: A step taken from count 0 loads the modulus when reload mode is 1 and 0xFFFF when it is 0, and sets the flag; with reload mode on, the flag thus rises (M+1)*2^(P+1) cycles after a restart with modulus M.
- R5: The interrupt output is high exactly when the flag and the interrupt-enable bit are both 1.
- R6: Writing 1 to flag bit 2 of the control word clears the flag; writing 0 leaves it; no write can set it.
- R7: A modulus write clears the flag; with overwrite set, the count reads the written value one cycle later.
- R8: With overwrite clear, a modulus write leaves the live count stepping as before, and the new value is used at the next reload.
- R9: A control write that changes nothing but bits 2 and 3 leaves the count and prescaler phase undisturbed.
- R10: Any other control write loads the count with the new limit (modulus in reload mode, else 0xFFFF) and clears the prescaler; with enable 0 the count holds.
- R11: When the counter expires on the same clock edge as a software clear of the flag (by control or modulus write), the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Write strobe for one cycle |
| regAddr | input | 3 | Byte offset of the register accessed |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr, combinational |
| irqOut | output | 1 | Level interrupt request |

## Verification
The hardest case is a flag clear that lands on the very edge where the counter expires, since the expiry edge depends on the prescaler phase set by an earlier restart. The bench counts clock edges from the restarting write, sets modulus 0 with the fastest prescale so the counter expires on every even edge, and then times control and modulus writes to fall on an even edge (flag must survive) and on an odd one (flag must clear). Sweeps over four prescale settings and four modulus values check every expiry cycle arithmetically.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 4;
  localparam int PRE_CNT_W = 1 << PRE_W;
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MOD   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd4;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic             restart;
    logic             overwrite;
    logic             run;
    logic [PRE_W-1:0] preSel;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] reloadVal;
  } dpStrobes_t;
endpackage

// File: rtl/dtimer_ctrl.sv
module dtimer_ctrl
  import dtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  input  logic              terminal,
  output logic [CNT_W-1:0]  ctrlWord,
  output logic [CNT_W-1:0]  modWord,
  output logic              irqLevel,
  output dpStrobes_t        strobes
);
  localparam int CFG_W = PRE_W + 5;

  logic             enQ, rldQ, flagQ, ieQ, ovwQ, dbgQ, dozeQ;
  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] modQ;

  logic             wrCtrl, wrMod, cfgChange, swClear;
  logic [CFG_W-1:0] cfgNow, cfgNew;
  logic [CNT_W-1:0] newLimit;

  always_comb begin
    wrCtrl    = regWrite && (regAddr == OFS_CTRL);
    wrMod     = regWrite && (regAddr == OFS_MOD);
    cfgNow    = {preQ, dozeQ, dbgQ, ovwQ, rldQ, enQ};
    cfgNew    = {regWdata[8 +: PRE_W], regWdata[6], regWdata[5], regWdata[4],
                 regWdata[1], regWdata[0]};
    cfgChange = wrCtrl && (cfgNow != cfgNew);
    swClear   = (wrCtrl && regWdata[2]) || wrMod;
    newLimit  = regWdata[1] ? modQ : {CNT_W{1'b1}};
  end

  always_comb begin
    strobes.restart   = cfgChange;
    strobes.overwrite = wrMod && ovwQ;
    strobes.run       = enQ;
    strobes.preSel    = preQ;
    strobes.loadVal   = cfgChange ? newLimit : regWdata;
    strobes.reloadVal = rldQ ? modQ : {CNT_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      rldQ  <= 1'b0;
      ovwQ  <= 1'b0;
      dbgQ  <= 1'b0;
      dozeQ <= 1'b0;
      preQ  <= '0;
      ieQ   <= 1'b0;
    end else if (wrCtrl) begin
      ieQ <= regWdata[3];
      if (cfgChange) begin
        enQ   <= regWdata[0];
        rldQ  <= regWdata[1];
        ovwQ  <= regWdata[4];
        dbgQ  <= regWdata[5];
        dozeQ <= regWdata[6];
        preQ  <= regWdata[8 +: PRE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      modQ <= {CNT_W{1'b1}};
    else if (wrMod) modQ <= regWdata;
  end

  // hardware expiry wins over a same-edge software clear
  always_ff @(posedge clk) begin
    if (!rstN)         flagQ <= 1'b0;
    else if (terminal) flagQ <= 1'b1;
    else if (swClear)  flagQ <= 1'b0;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = enQ;
    ctrlWord[1] = rldQ;
    ctrlWord[2] = flagQ;
    ctrlWord[3] = ieQ;
    ctrlWord[4] = ovwQ;
    ctrlWord[5] = dbgQ;
    ctrlWord[6] = dozeQ;
    ctrlWord[8 +: PRE_W] = preQ;
    modWord  = modQ;
    irqLevel = flagQ && ieQ;
  end
endmodule

// File: rtl/dtimer_datapath.sv
module dtimer_datapath
  import dtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  output logic [CNT_W-1:0] countQ,
  output logic             terminal
);
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] divTop;
  logic [PRE_W:0]       shAmt;
  logic                 tick, loadNow;

  always_comb begin
    shAmt    = (PRE_W+1)'(PRE_CNT_W-1) - {1'b0, strobes.preSel};
    divTop   = {PRE_CNT_W{1'b1}} >> shAmt;
    tick     = strobes.run && (preCnt == divTop);
    loadNow  = strobes.restart || strobes.overwrite;
    terminal = tick && (countQ == '0) && !loadNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 preCnt <= '0;
    else if (strobes.restart)  preCnt <= '0;
    else if (tick)             preCnt <= '0;
    else if (strobes.run)      preCnt <= preCnt + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         countQ <= {CNT_W{1'b1}};
    else if (loadNow)  countQ <= strobes.loadVal;
    else if (terminal) countQ <= strobes.reloadVal;
    else if (tick)     countQ <= countQ - CNT_W'(1);
  end
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer
  import dtimer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        irqOut
);
  dpStrobes_t       strobes;
  logic [CNT_W-1:0] ctrlView, modView, countQ;
  logic             terminal;

  dtimer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .terminal(terminal), .ctrlWord(ctrlView),
    .modWord(modView), .irqLevel(irqOut), .strobes(strobes)
  );

  dtimer_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .countQ(countQ), .terminal(terminal)
  );

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:  regRdata = ctrlView;
      OFS_MOD:   regRdata = modView;
      OFS_COUNT: regRdata = countQ;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrite,
  input logic [2:0]  regAddr,
  input logic [15:0] regWdata,
  input logic [15:0] ctrlView,
  input logic [15:0] countQ,
  input logic        terminal,
  input logic        irqOut
);
  // R4
  term_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    terminal |=> ctrlView[2]);
  // R6
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !terminal |=> !$rose(ctrlView[2]));
  // R7
  mod_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd2 && !terminal) |=> !ctrlView[2]);
  // R7
  overwrite_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd2 && ctrlView[4]) |=> countQ == $past(regWdata));
  // R5
  irq_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[2] && ctrlView[3]) |-> irqOut);
  // R5
  irq_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlView[2] |-> !irqOut);
  // R2
  count_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == 3'd4 && !ctrlView[0]) |=> $stable(countQ));
  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlView[0] && !regWrite) |=> $stable(countQ));
endmodule

bind irq_down_timer dtimer_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .ctrlView(ctrlView), .countQ(countQ),
  .terminal(terminal), .irqOut(irqOut)
);

// File: tb/irq_down_timer_tb.sv
`timescale 1ns/1ps
module irq_down_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        irqOut;

  int nChk = 0, nErr = 0, cyc = 0, cyc0 = 0;
  bit done = 0;

  localparam logic [15:0] EN = 16'h0001, RLD = 16'h0002, FLG = 16'h0004,
                          IE = 16'h0008, OVW = 16'h0010;

  irq_down_timer u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic waitUntil(input int n);
    while (cyc - cyc0 < n) begin @(posedge clk); #1; end
  endtask

  task automatic markStart();
    cyc0 = cyc;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int N, T;
    waitCyc(4);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd2, v); chk("R1 mod", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 count", v, 16'hFFFF);
    chk("R1 irq", irqOut, 1'b0);

    // R2 readback, unused bits, count writes
    wr(3'd0, 16'h0060);
    rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0060);
    wr(3'd0, 16'hF0E0);
    rd(3'd0, v); chk("R2 unused bits zero", v, 16'h0060);
    wr(3'd4, 16'h1234);
    rd(3'd4, v); chk("R2 count write ignored", v, 16'hFFFF);
    wr(3'd2, 16'h0005);
    rd(3'd2, v); chk("R2 mod readback", v, 16'h0005);
    rd(3'd6, v); chk("R2 unmapped reads zero", v, 16'h0000);
    wr(3'd0, 16'h0000);

    // R3 R4 R5 sweep of prescale and modulus in reload mode
    for (int p = 0; p < 4; p++) begin
      for (int lim = 0; lim < 4; lim++) begin
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'(lim));
        wr(3'd0, EN | RLD | IE | 16'(p << 8));
        markStart();
        N = 2 << p;
        T = (lim + 1) * N;
        for (int k = 1; k <= T; k++) begin
          @(posedge clk); #1;
          if (k == N && lim > 0) begin
            rd(3'd4, v); chk("R3 first step", v, 16'(lim - 1));
          end
          if (k == T - 1) chk("R5 irq before expiry", irqOut, 1'b0);
          if (k == T) begin
            chk("R4 irq at expiry", irqOut, 1'b1);
            rd(3'd4, v); chk("R4 reload modulus", v, 16'(lim));
          end
        end
      end
    end

    // R4 R7 free-running wrap with overwrite
    wr(3'd0, 16'h0000);
    wr(3'd0, EN | OVW);
    wr(3'd2, 16'h0003);
    rd(3'd4, v); chk("R7 overwrite loads count", v, 16'h0003);
    rd(3'd0, v); chk("R7 mod write clears flag", v[2], 1'b0);
    waitCyc(10);
    rd(3'd4, v); chk("R4 wrap to full scale", (v >= 16'hFFF8), 1'b1);
    rd(3'd0, v); chk("R4 flag on wrap", v[2], 1'b1);

    // R5 R6 flag gating and clearing
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0001);
    wr(3'd0, EN | RLD);
    waitCyc(6);
    rd(3'd0, v); chk("R6 flag set by expiry", v[2], 1'b1);
    chk("R5 irq masked", irqOut, 1'b0);
    wr(3'd0, EN | RLD | IE);
    rd(3'd0, v); chk("R6 write 0 keeps flag", v[2], 1'b1);
    chk("R5 irq enabled", irqOut, 1'b1);
    wr(3'd0, IE | RLD);
    rd(3'd0, v); chk("R6 flag kept on stop", v[2], 1'b1);
    wr(3'd0, IE | RLD | FLG);
    rd(3'd0, v); chk("R6 w1c clears", v[2], 1'b0);
    chk("R5 irq low after clear", irqOut, 1'b0);
    wr(3'd0, IE | RLD | FLG);
    rd(3'd0, v); chk("R6 cannot set", v[2], 1'b0);

    // R9 R10 undisturbed vs restarting writes
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd200);
    wr(3'd0, EN | RLD);
    markStart();
    waitCyc(11);
    wr(3'd0, EN | RLD | IE);
    waitCyc(5);
    rd(3'd4, v); chk("R9 count undisturbed", v, 16'(200 - (cyc - cyc0) / 2));
    wr(3'd0, EN | RLD | IE | 16'h0100);
    rd(3'd4, v); chk("R10 restart loads limit", v, 16'd200);
    waitCyc(3);
    rd(3'd4, v); chk("R10 prescaler cleared", v, 16'd200);
    waitCyc(1);
    rd(3'd4, v); chk("R10 first step after restart", v, 16'd199);
    wr(3'd0, RLD | IE | 16'h0100);
    rd(3'd4, v); chk("R10 stop loads limit", v, 16'd200);
    waitCyc(20);
    rd(3'd4, v); chk("R10 halted count holds", v, 16'd200);

    // R8 deferred modulus
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd3);
    wr(3'd0, EN | RLD);
    markStart();
    waitUntil(2);
    wr(3'd2, 16'd1);
    rd(3'd4, v); chk("R8 count not reloaded", v, 16'(3 - (cyc - cyc0) / 2));
    waitUntil(8);
    rd(3'd4, v); chk("R8 new modulus at reload", v, 16'd1);
    waitUntil(10);
    rd(3'd4, v); chk("R8 step after reload", v, 16'd0);
    waitUntil(12);
    rd(3'd4, v); chk("R8 second reload", v, 16'd1);

    // R11 clear racing expiry
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd0);
    wr(3'd0, EN | RLD | IE);
    markStart();
    waitUntil(4);
    wr(3'd0, EN | RLD | IE | FLG);
    rd(3'd0, v); chk("R6 off-edge clear", v[2], 1'b0);
    wr(3'd0, EN | RLD | IE | FLG);
    rd(3'd0, v); chk("R11 ctrl clear loses to expiry", v[2], 1'b1);
    waitUntil(9);
    wr(3'd2, 16'd0);
    rd(3'd0, v); chk("R11 mod clear loses to expiry", v[2], 1'b1);
    waitUntil(12);
    wr(3'd2, 16'd0);
    rd(3'd0, v); chk("R7 off-edge mod clear", v[2], 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule